// File: doc/BRIEF.md
# PCM Serial Time-Slot Port

This block is the digital serial side of a telephony voice codec. Once per 8 kHz frame it sends one 8-bit companded sample out of a tri-state data pin and captures one 8-bit sample from a serial input. Each direction has its own bit clock and frame sync. A fast system clock samples every serial input through a two-flop synchronizer and finds the edges. The system clock must run at least eight times faster than the fastest bit clock.

The port works out the frame-sync style from the width of the transmit sync. A pulse one bit period wide gives short-frame timing. A pulse three or more periods wide gives long-frame timing. In long-frame timing, the output enable and the output disable each follow the later of two events. The sample to send is taken from a parallel input when a transmit slot opens. A received sample appears on a parallel output together with a one-cycle strobe.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is held and just after it is released, `tx_oe` = 0, `tx_dout` = 0, `slot_n` = 1, `long_mode` = 0 (short framing) and `rx_valid` = 0.
- R2: A transition on any serial input (`tx_bclk`, `tx_fs`, `rx_bclk`, `rx_fs`, `rx_din`) acts on the outputs at the third rising `clk` edge after the input changes.
- R3: When a transmit slot opens, the port loads `tx_sample` and drives bit 7 first. Each later rising `tx_bclk` edge moves to the next lower bit. After bit 0 the output stays on bit 0, so exactly 8 distinct bits go out per slot.
- R4: Short framing, transmit: `tx_fs` must be seen high at a falling `tx_bclk` edge. The next rising edge then opens the slot. The falling edge that follows the eighth driven bit's rising edge (the last of seven further rising edges) closes the slot.
- R5: Long framing, transmit: the slot opens at the later of the `tx_fs` rising edge and a rising `tx_bclk` edge. If `tx_bclk` is already high when `tx_fs` rises, the slot opens at once.
- R6: Long framing, transmit: the slot closes at the later of two events. One is the falling `tx_bclk` edge after the eighth bit. The other is `tx_fs` going low.
- R7: At each falling edge of `tx_fs`, `long_mode` is set to 1 if `tx_fs` was high at 2 or more falling `tx_bclk` edges. Otherwise it is cleared to 0. Both directions use this value from then on.
- R8: Short framing, receive: `rx_fs` must be seen high at a falling `rx_bclk` edge. The next 8 falling edges then latch `rx_din`, bit 7 first.
- R9: Long framing, receive: a rising edge of `rx_fs` starts a capture, and the next 8 falling `rx_bclk` edges latch `rx_din`, bit 7 first.
- R10: At the eighth latched bit, `rx_sample` takes the new byte and `rx_valid` is high for exactly one `clk` cycle.
- R11: `slot_n` is low exactly while `tx_oe` is high. `tx_dout` is 0 whenever `tx_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_sample | input | 8 | Byte sent in the next transmit slot |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| tx_dout | output | 1 | Serial transmit data, valid while tx_oe is high |
| tx_oe | output | 1 | Enable for the external tri-state output buffer |
| slot_n | output | 1 | Active-low transmit time-slot indicator |
| long_mode | output | 1 | 1 = long framing detected, 0 = short framing |
| rx_sample | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_sample updates |

## Verification
Every output reacts three system-clock edges after the serial input transition that causes it: two synchronizer stages and one state register. The reference model in the bench responds to the inputs with no delay and puts its expectation into a queue each cycle. That expectation is compared with the design's outputs three cycles later. The frame-level checks read `tx_dout` and `tx_oe` at the sixth system clock of each bit period, by which time that period's rising-edge update has settled. They read `rx_sample` only after the frame has ended, so every check falls well after the three-cycle delay.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int W        = 8,
  parameter int LONG_MIN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_bclk,
  input  logic         tx_fs,
  input  logic [W-1:0] tx_sample,
  input  logic         rx_bclk,
  input  logic         rx_fs,
  input  logic         rx_din,
  output logic         tx_dout,
  output logic         tx_oe,
  output logic         slot_n,
  output logic         long_mode,
  output logic [W-1:0] rx_sample,
  output logic         rx_valid
);
  localparam int CW = $clog2(W + 1);
  localparam int FW = $clog2(LONG_MIN + 1);

  logic [4:0] s1, s2, s3;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {rx_din, rx_fs, rx_bclk, tx_fs, tx_bclk};
      s2 <= s1;
      s3 <= s2;
    end
  end

  wire tbclk    = s2[0];
  wire tfs      = s2[1];
  wire rfs      = s2[3];
  wire rdin     = s2[4];
  wire t_rise   =  s2[0] & ~s3[0];
  wire t_fall   = ~s2[0] &  s3[0];
  wire tfs_rise =  s2[1] & ~s3[1];
  wire tfs_fall = ~s2[1] &  s3[1];
  wire r_fall   = ~s2[2] &  s3[2];
  wire rfs_rise =  s2[3] & ~s3[3];

  logic [FW-1:0] fcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= '0;
      long_mode <= 1'b0;
    end else begin
      if (tfs_rise) fcnt <= '0;
      else if (tfs && t_fall && fcnt != FW'(LONG_MIN)) fcnt <= fcnt + 1'b1;
      if (tfs_fall) long_mode <= (fcnt >= FW'(LONG_MIN));
    end
  end

  logic          busy, armed, done;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  wire start    = !busy && (long_mode ? ((armed | tfs_rise) & tbclk) : (armed & t_rise));
  wire end_bits = busy & (done | (t_fall & (cnt == CW'(W))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; armed <= 1'b0; done <= 1'b0;
      cnt <= '0; sh <= '0;
    end else if (start) begin
      busy <= 1'b1; armed <= 1'b0; done <= 1'b0;
      cnt <= CW'(1); sh <= tx_sample;
    end else begin
      if (!busy && (long_mode ? tfs_rise : (t_fall & tfs))) armed <= 1'b1;
      if (busy && t_rise && cnt != CW'(W)) begin
        cnt <= cnt + 1'b1;
        sh  <= sh << 1;
      end
      if (end_bits) begin
        if (!long_mode || !tfs) begin
          busy <= 1'b0;
          done <= 1'b0;
        end else begin
          done <= 1'b1;
        end
      end
    end
  end

  assign tx_oe   = busy;
  assign tx_dout = busy & sh[W-1];
  assign slot_n  = ~busy;

  logic          rbusy;
  logic [CW-1:0] rcnt;
  logic [W-1:0]  rsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbusy <= 1'b0; rcnt <= '0; rsh <= '0;
      rx_sample <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!rbusy) begin
        if (long_mode ? rfs_rise : (r_fall & rfs)) begin
          rbusy <= 1'b1;
          rcnt  <= '0;
        end
      end else if (r_fall) begin
        rsh <= {rsh[W-2:0], rdin};
        if (rcnt == CW'(W - 1)) begin
          rbusy     <= 1'b0;
          rx_sample <= {rsh[W-2:0], rdin};
          rx_valid  <= 1'b1;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3
  slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> $past(cnt) == CW'(W));

  // R5
  open_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(tbclk));

  // R6
  long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_oe) && $past(long_mode)) |-> !$past(tfs));

  // R3
  dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && $past(tx_oe) && !$past(t_rise)) |-> $stable(tx_dout));
endmodule

// File: tb/sim_pcm_slot_port.sv
module sim_pcm_slot_port;
  logic clk = 0, rst_n = 0;
  logic tx_bclk = 0, tx_fs = 0, rx_bclk = 0, rx_fs = 0, rx_din = 0;
  logic [7:0] tx_sample = 0;
  logic tx_dout, tx_oe, slot_n, long_mode, rx_valid;
  logic [7:0] rx_sample;

  pcm_slot_port u0 (.clk(clk), .rst_n(rst_n), .tx_bclk(tx_bclk), .tx_fs(tx_fs),
    .tx_sample(tx_sample), .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_din(rx_din),
    .tx_dout(tx_dout), .tx_oe(tx_oe), .slot_n(slot_n), .long_mode(long_mode),
    .rx_sample(rx_sample), .rx_valid(rx_valid));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: reacts instantly, compared three cycles later (R2)
  bit p_tb, p_tfs, p_rb, p_rfs;
  bit m_long, m_busy, m_armed, m_done, m_val;
  int m_fc;
  bit m_bits[$];
  bit r_on;
  bit r_bits[$];
  logic [7:0] m_rxs;
  logic [12:0] expq[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_long = 0; m_busy = 0; m_armed = 0; m_done = 0; m_val = 0; m_fc = 0;
      m_bits.delete(); r_on = 0; r_bits.delete(); m_rxs = 0; expq.delete();
    end else begin
      if (expq.size() == 3) begin
        logic [12:0] e;
        e = expq.pop_front();
        chk(tx_oe == e[12], "R4 R5 R6 tx_oe", tx_oe, e[12]);
        chk(tx_dout == e[11], "R3 tx_dout", tx_dout, e[11]);
        chk(slot_n == e[10], "R11 slot_n", slot_n, e[10]);
        chk(long_mode == e[9], "R7 long_mode", long_mode, e[9]);
        chk(rx_valid == e[8], "R10 rx_valid", rx_valid, e[8]);
        chk(rx_sample == e[7:0], "R8 R9 rx_sample", rx_sample, e[7:0]);
      end
      begin
        bit tr, tf, fr, ff, rf, rr, lg, st;
        tr = tx_bclk && !p_tb;  tf = !tx_bclk && p_tb;
        fr = tx_fs && !p_tfs;   ff = !tx_fs && p_tfs;
        rf = !rx_bclk && p_rb;  rr = rx_fs && !p_rfs;
        lg = m_long;
        if (fr) m_fc = 0;
        else if (tx_fs && tf && m_fc < 2) m_fc++;
        if (ff) m_long = (m_fc >= 2);
        st = !m_busy && (lg ? ((m_armed || fr) && tx_bclk) : (m_armed && tr));
        if (st) begin
          m_busy = 1; m_armed = 0; m_done = 0;
          m_bits.delete();
          for (int i = 7; i >= 0; i--) m_bits.push_back(tx_sample[i]);
        end else begin
          if (!m_busy && (lg ? fr : (tf && tx_fs))) m_armed = 1;
          if (m_busy && tr && m_bits.size() > 1) void'(m_bits.pop_front());
          if (m_busy && (m_done || (tf && m_bits.size() == 1))) begin
            if (!lg || !tx_fs) begin m_busy = 0; m_done = 0; end
            else m_done = 1;
          end
        end
        m_val = 0;
        if (!r_on) begin
          if (lg ? rr : (rf && rx_fs)) begin r_on = 1; r_bits.delete(); end
        end else if (rf) begin
          r_bits.push_back(rx_din);
          if (r_bits.size() == 8) begin
            for (int i = 0; i < 8; i++) m_rxs[7-i] = r_bits[i];
            m_val = 1; r_on = 0;
          end
        end
        expq.push_back({m_busy, m_busy && m_bits[0], !m_busy, m_long, m_val, m_rxs});
      end
    end
    p_tb = tx_bclk; p_tfs = tx_fs; p_rb = rx_bclk; p_rfs = rx_fs;
  end

  task automatic frame(input int wid, input int off, input logic [7:0] tb,
                       input logic [7:0] rb, input bit rxlong, input int exp_oe,
                       input string tag);
    logic [7:0] cap = 0;
    int ncap = 0, noe = 0;
    int nper = (wid + 10 > 12) ? wid + 10 : 12;
    int rw = rxlong ? 3 : 1;
    for (int p = 0; p < nper; p++) begin
      for (int c = 0; c < 8; c++) begin
        @(posedge clk); #1;
        if (p == 0 && c == 0) tx_sample = tb;
        tx_bclk = (c < 4); rx_bclk = (c < 4);
        if (p == 0 && c == off) tx_fs = 1;
        if (p == wid && c == off) tx_fs = 0;
        if (p == 0 && c == 1) rx_fs = 1;
        if (p == rw && c == 1) rx_fs = 0;
        if (c == 0) begin
          int k = rxlong ? p : p - 1;
          rx_din = (k >= 0 && k < 8) ? rb[7-k] : 1'b0;
        end
        if (c == 6 && tx_oe) begin
          noe++;
          if (ncap < 8) begin cap = {cap[6:0], tx_dout}; ncap++; end
        end
      end
    end
    repeat (16) @(posedge clk);
    #1;
    chk(cap == tb, {tag, " R3 tx byte"}, cap, tb);
    chk(noe == exp_oe, {tag, " R4 R5 R6 slot length"}, noe, exp_oe);
    chk(rx_sample == rb, {tag, rxlong ? " R9 rx byte" : " R8 rx byte"}, rx_sample, rb);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1
    chk(tx_oe == 0 && tx_dout == 0, "R1 reset tx_oe", tx_oe, 0);
    chk(slot_n == 1, "R1 reset slot_n", slot_n, 1);
    chk(long_mode == 0 && rx_valid == 0, "R1 reset mode/valid", long_mode, 0);
    rst_n = 1;
    repeat (5) @(posedge clk);
    #1;
    chk(tx_oe == 0 && long_mode == 0, "R1 after release", tx_oe, 0);
    frame(1, 1, 8'hA5, 8'h3C, 0, 8, "short");
    chk(long_mode == 0, "R7 stays short", long_mode, 0);
    frame(3, 1, 8'h81, 8'h7E, 0, 8, "switch");
    chk(long_mode == 1, "R7 becomes long", long_mode, 1);
    frame(3, 1, 8'h5A, 8'hC3, 1, 8, "long-now");
    frame(3, 5, 8'hF0, 8'h0F, 1, 8, "long-wait");
    frame(10, 1, 8'h96, 8'h69, 1, 10, "long-hold");
    chk(long_mode == 1, "R7 still long", long_mode, 1);
    frame(1, 1, 8'h01, 8'hFE, 1, 8, "back");
    chk(long_mode == 0, "R7 back to short", long_mode, 0);
    frame(1, 1, 8'hFF, 8'h00, 0, 8, "short2");
    finished = 1;
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule